// File: doc/BRIEF.md
# Four-Master Processor Bus Arbiter

This block decides which of up to four processors may drive a shared processor bus. Each processor has an active-low request and an active-low grant. A grant stays with its owner until a transfer-complete strobe arrives. The block also drives, for each processor, an active-low hard reset, an active-low soft reset and an active-low machine-check line. A small register port carries the mode control, the reset controls, error status, and a readback of the current bus owner.

After reset only processors 0 and 1 take part in arbitration. Processors 2 and 3 are held in hard and soft reset. When software sets the wide-mode bit, processors 2 and 3 join the round-robin rotation and their resets are released in the same write. The reset control bits for processors 2 and 3 can then be driven again by software. A processor whose hard reset is held is never granted the bus.

When an error is reported while a grant is held, the block pulses a machine-check pair. One internal source drives the lines of processors 0 and 2, and another drives the lines of processors 1 and 3. A sticky status register records such errors only when processor 0 or processor 1 owns the bus.

Top module: `mpbus_arbiter`

## Requirements
- R1: Out of reset the block is in two-master mode: only processors 0 and 1 can be granted, and requests from processors 2 and 3 are ignored.
- R2: Writing register 0 with bit 0 set selects four-master mode and clears both the hard-reset bits and the soft-reset bits of processors 2 and 3 in the same write. Writing bit 0 clear returns the block to two-master mode. Register 0 bit 0 reads back the mode.
- R3: Register 1 bits [1:0] drive the hard resets of processors 2 and 3 (bit 0 for processor 2), and a 1 holds that processor in reset (line low). Both bits reset to 1.
- R4: Register 2 bits [1:0] drive the soft resets of processors 2 and 3 in the same way (bit 0 for processor 2, 1 = asserted). Both bits reset to 1.
- R5: Register 3 bits [7:0] read back the index (0 to 3) of the processor that owns the bus. While the bus is idle they keep the last owner, and they read 0 after reset.
- R6: An error strobe sampled while a grant is held drives a one-cycle machine-check pulse on the next cycle. If the owner index is even, the lines of processors 0 and 2 go low; if it is odd, the lines of processors 1 and 3 go low.
- R7: Register 3 bits [9:8] are sticky error flags for processors 0 and 1 (bit 8 for processor 0). They are set by an error while that processor owns the bus, and are cleared by writing 1 to the bit. Errors while processor 2 or 3 owns the bus are not recorded.
- R8: Arbitration is round-robin. The search starts at the processor after the last one granted, and the first grant after reset goes to processor 0. A grant appears in the cycle after an eligible request is sampled on an idle bus. It holds until the transfer-complete strobe, and it is withdrawn in the next cycle. At least one idle cycle separates two grants.
- R9: At most one grant is active at any time.
- R10: In four-master mode, a processor whose hard-reset bit is set is skipped by arbitration.
- R11: All hard and soft resets are low while the block is in reset. Those of processors 0 and 1 are high from the first clock after the internal reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Bus requests, active low, one per processor |
| xfer_done | input | 1 | Transfer-complete strobe, active high |
| bus_err | input | 1 | Error strobe for the current transfer, active high |
| gnt_n | output | 4 | Bus grants, active low |
| hreset_n | output | 4 | Hard resets, active low |
| sreset_n | output | 4 | Soft resets, active low |
| mchk_n | output | 4 | Machine-check lines, active low, shared in pairs 0/2 and 1/3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
The bench first drives all four requests in two-master mode. A design that leaked processor 2 or 3 into the rotation would show a grant the scoreboard did not expect. After four-master mode is selected, the bench checks the rotation order across the mode change and skips a processor held in hard reset. A pointer that failed to advance past the last owner, or that ignored the reset bit, would reorder the grants. Errors are injected while processor 2 owns the bus and while processor 1 owns it. A wrong pairing drives the wrong machine-check lines, and a status register that also tracked processors 2 and 3 would show a flag that should stay clear. A long hold without the completion strobe catches a grant that drops early or a re-grant in the release cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_HRST   = 2'd1,
    REG_SRST   = 2'd2,
    REG_STATUS = 2'd3
  } arb_reg_e;

  localparam int unsigned STAT_LSB = 8;
  localparam int unsigned MCHK_SRC = 2;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] cand;

  always_comb begin
    any  = 1'b0;
    idx  = last;
    cand = last;
    for (int k = 1; k <= int'(N); k++) begin
      cand = IW'((int'(last) + k) % int'(N));
      if (!any && elig[cand]) begin
        any = 1'b1;
        idx = cand;
      end
    end
  end
endmodule

// File: rtl/arb_grant.sv
module arb_grant #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          xfer_done,
  output logic [N-1:0]  gnt,
  output logic          busy,
  output logic [IW-1:0] owner
);
  logic          busy_q, busy_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [IW-1:0] last_q, last_d;
  logic [N-1:0]  gnt_q, gnt_d;
  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic          upd_en;

  arb_rr_pick #(.N(N)) u_pick (
    .elig (elig),
    .last (last_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    last_d  = last_q;
    gnt_d   = gnt_q;
    upd_en  = 1'b0;
    if (busy_q) begin
      if (xfer_done) begin
        busy_d = 1'b0;
        gnt_d  = '0;
        upd_en = 1'b1;
      end
    end else if (pick_any) begin
      busy_d          = 1'b1;
      owner_d         = pick_idx;
      last_d          = pick_idx;
      gnt_d           = '0;
      gnt_d[pick_idx] = 1'b1;
      upd_en          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(N - 1);
      gnt_q   <= '0;
    end else if (upd_en) begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      last_q  <= last_d;
      gnt_q   <= gnt_d;
    end
  end

  assign gnt   = gnt_q;
  assign busy  = busy_q;
  assign owner = owner_q;
endmodule

// File: rtl/arb_ctl_regs.sv
module arb_ctl_regs
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXT_M  = 2,
  parameter int unsigned BASE_M = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              mode_q,
  output logic [EXT_M-1:0]  hrst_q,
  output logic [EXT_M-1:0]  srst_q,
  output logic [BASE_M-1:0] stat_clr
);
  logic             mode_d;
  logic [EXT_M-1:0] hrst_d, srst_d;
  logic             reg_en;

  always_comb begin
    mode_d   = mode_q;
    hrst_d   = hrst_q;
    srst_d   = srst_q;
    reg_en   = 1'b0;
    stat_clr = '0;
    if (reg_wr) begin
      case (reg_addr)
        ADDR_W'(REG_MODE): begin
          reg_en = 1'b1;
          mode_d = reg_wdata[0];
          if (reg_wdata[0]) begin
            hrst_d = '0;
            srst_d = '0;
          end
        end
        ADDR_W'(REG_HRST): begin
          reg_en = 1'b1;
          hrst_d = reg_wdata[EXT_M-1:0];
        end
        ADDR_W'(REG_SRST): begin
          reg_en = 1'b1;
          srst_d = reg_wdata[EXT_M-1:0];
        end
        default: stat_clr = reg_wdata[STAT_LSB +: BASE_M];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      hrst_q <= '1;
      srst_q <= '1;
    end else if (reg_en) begin
      mode_q <= mode_d;
      hrst_q <= hrst_d;
      srst_q <= srst_d;
    end
  end
endmodule

// File: rtl/arb_err.sv
module arb_err
  import arb_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned BASE_M = 2,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_err,
  input  logic              busy,
  input  logic [IW-1:0]     owner,
  input  logic [BASE_M-1:0] stat_clr,
  output logic [MCHK_SRC-1:0] mchk_src,
  output logic [BASE_M-1:0] status
);
  logic [MCHK_SRC-1:0] src_q, src_d;
  logic [BASE_M-1:0]   stat_q, stat_d;
  logic                err_live;

  assign err_live = bus_err & busy;

  for (genvar s = 0; s < int'(MCHK_SRC); s++) begin : g_src
    assign src_d[s] = err_live && ((int'(owner) % int'(MCHK_SRC)) == s);
  end

  for (genvar b = 0; b < int'(BASE_M); b++) begin : g_stat
    assign stat_d[b] = (err_live && (int'(owner) == b)) |
                       (stat_q[b] & ~stat_clr[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      stat_q <= '0;
    end else begin
      src_q  <= src_d;
      stat_q <= stat_d;
    end
  end

  assign mchk_src = src_q;
  assign status   = stat_q;
endmodule

// File: rtl/mpbus_arbiter.sv
module mpbus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_M  = 4,
  parameter int unsigned BASE_M = 2,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_M-1:0]  req_n,
  input  logic              xfer_done,
  input  logic              bus_err,
  output logic [NUM_M-1:0]  gnt_n,
  output logic [NUM_M-1:0]  hreset_n,
  output logic [NUM_M-1:0]  sreset_n,
  output logic [NUM_M-1:0]  mchk_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned EXT_M = NUM_M - BASE_M;
  localparam int unsigned IW    = $clog2(NUM_M);

  logic [1:0]          rst_pipe;
  logic                rst_s_n;
  logic                core_up_q;
  logic                mode_q;
  logic [EXT_M-1:0]    hrst_q, srst_q;
  logic [BASE_M-1:0]   stat_clr, status;
  logic [NUM_M-1:0]    elig, gnt;
  logic                busy;
  logic [IW-1:0]       owner;
  logic [MCHK_SRC-1:0] mchk_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) core_up_q <= 1'b0;
    else          core_up_q <= 1'b1;
  end

  arb_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_M(EXT_M), .BASE_M(BASE_M)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .mode_q   (mode_q),
    .hrst_q   (hrst_q),
    .srst_q   (srst_q),
    .stat_clr (stat_clr)
  );

  for (genvar i = 0; i < int'(NUM_M); i++) begin : g_m
    if (i < int'(BASE_M)) begin : g_base
      assign elig[i]     = ~req_n[i];
      assign hreset_n[i] = core_up_q;
      assign sreset_n[i] = core_up_q;
    end else begin : g_ext
      assign elig[i]     = ~req_n[i] & mode_q & ~hrst_q[i-BASE_M];
      assign hreset_n[i] = ~hrst_q[i-BASE_M];
      assign sreset_n[i] = ~srst_q[i-BASE_M];
    end
    assign gnt_n[i]  = ~gnt[i];
    assign mchk_n[i] = ~mchk_src[i % int'(MCHK_SRC)];
  end

  arb_grant #(.N(NUM_M)) u_grant (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .elig     (elig),
    .xfer_done(xfer_done),
    .gnt      (gnt),
    .busy     (busy),
    .owner    (owner)
  );

  arb_err #(.N(NUM_M), .BASE_M(BASE_M)) u_err (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .bus_err (bus_err),
    .busy    (busy),
    .owner   (owner),
    .stat_clr(stat_clr),
    .mchk_src(mchk_src),
    .status  (status)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(REG_MODE): reg_rdata[0]         = mode_q;
      ADDR_W'(REG_HRST): reg_rdata[EXT_M-1:0] = hrst_q;
      ADDR_W'(REG_SRST): reg_rdata[EXT_M-1:0] = srst_q;
      default: begin
        reg_rdata[IW-1:0]             = owner;
        reg_rdata[STAT_LSB +: BASE_M] = status;
      end
    endcase
  end
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rst_s_n,
  input logic [3:0] gnt_n,
  input logic       xfer_done,
  input logic       mode_q,
  input logic [3:0] hreset_n,
  input logic       bus_err,
  input logic       busy,
  input logic [1:0] owner,
  input logic [3:0] mchk_n
);
  a_r9_one_grant: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(~gnt_n));

  a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_s_n)
    (gnt_n != 4'hF && !xfer_done) |=> $stable(gnt_n));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_s_n)
    (gnt_n != 4'hF && xfer_done) |=> gnt_n == 4'hF);

  a_r1_wide_only: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($fell(gnt_n[2]) || $fell(gnt_n[3])) |-> $past(mode_q));

  a_r10_skip_held: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(gnt_n[2]) |-> $past(hreset_n[2]));

  a_r6_even_pair: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_err && busy && !owner[0]) |=> (!mchk_n[0] && !mchk_n[2] && mchk_n[1]));

  a_r6_odd_pair: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_err && busy && owner[0]) |=> (!mchk_n[1] && !mchk_n[3] && mchk_n[0]));

  a_r11_base_up: assert property (@(posedge clk) disable iff (!rst_s_n)
    rst_s_n |=> hreset_n[1:0] == 2'b11);
endmodule

bind mpbus_arbiter arb_checker u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .gnt_n    (gnt_n),
  .xfer_done(xfer_done),
  .mode_q   (mode_q),
  .hreset_n (hreset_n),
  .bus_err  (bus_err),
  .busy     (busy),
  .owner    (owner),
  .mchk_n   (mchk_n)
);

// File: tb/sim_mpbus_arbiter.sv
`timescale 1ns/1ps
module sim_mpbus_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req_n;
  logic        xfer_done, bus_err;
  logic [3:0]  gnt_n, hreset_n, sreset_n, mchk_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int exp_q[$];
  logic [3:0] prev_gnt = 4'hF;
  logic [31:0] rd_v;

  always #10 clk = ~clk;

  mpbus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .xfer_done(xfer_done),
    .bus_err(bus_err), .gnt_n(gnt_n), .hreset_n(hreset_n),
    .sreset_n(sreset_n), .mchk_n(mchk_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int gidx(input logic [3:0] g);
    for (int i = 0; i < 4; i++) if (!g[i]) return i;
    return -1;
  endfunction

  // scoreboard monitor: each new grant is compared with the next expected master
  always @(negedge clk) begin
    if (prev_gnt == 4'hF && gnt_n != 4'hF) begin
      if (exp_q.size() == 0)
        check(1'b0, "R8 unexpected grant", gidx(gnt_n), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(gidx(gnt_n) == e && $countones(~gnt_n) == 1, "R8 grant order",
              int'(gnt_n), int'(~(4'b1 << e)) & 4'hF);
      end
    end
    prev_gnt <= gnt_n;
  end

  task automatic push(input int m);
    exp_q.push_back(m);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_grant();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (gnt_n == 4'hF && k < 50);
  endtask

  task automatic serve(input int n);
    for (int j = 0; j < n; j++) begin
      wait_grant();
      rd(2'd3, rd_v);
      check(int'(rd_v[7:0]) == gidx(gnt_n), "R5 owner readback", int'(rd_v[7:0]), gidx(gnt_n));
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
    end
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_n = 4'hF; xfer_done = 1'b0; bus_err = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 / R3 / R4 / R5 reset state
    check(hreset_n == 4'b0011, "R11 hard resets", hreset_n, 4'b0011);
    check(sreset_n == 4'b0011, "R11 soft resets", sreset_n, 4'b0011);
    check(gnt_n == 4'hF, "R9 no grant at reset", gnt_n, 4'hF);
    check(mchk_n == 4'hF, "R6 no machine check", mchk_n, 4'hF);
    rd(2'd1, rd_v); check(rd_v == 32'd3, "R3 reset value", rd_v, 3);
    rd(2'd2, rd_v); check(rd_v == 32'd3, "R4 reset value", rd_v, 3);
    rd(2'd3, rd_v); check(rd_v == 32'd0, "R5 reset owner", rd_v, 0);
    rd(2'd0, rd_v); check(rd_v == 32'd0, "R1 two-master mode", rd_v, 0);

    // R1: all request, only 0 and 1 rotate
    req_n = 4'b0000;
    push(0); push(1); push(0); push(1);
    serve(4);
    req_n = 4'b0011;
    repeat (6) @(negedge clk);
    check(gnt_n == 4'hF, "R1 masters 2/3 ignored", gnt_n, 4'hF);
    rd(2'd3, rd_v); check(rd_v[7:0] == 8'd1, "R5 idle keeps last owner", rd_v[7:0], 1);
    req_n = 4'hF;

    // R2: enable four-master mode
    wr(2'd0, 32'd1);
    check(hreset_n == 4'hF, "R2 hard resets released", hreset_n, 4'hF);
    check(sreset_n == 4'hF, "R2 soft resets released", sreset_n, 4'hF);
    rd(2'd0, rd_v); check(rd_v == 32'd1, "R2 mode readback", rd_v, 1);
    req_n = 4'b0000;
    push(2); push(3); push(0); push(1);
    serve(4);
    req_n = 4'hF;

    // R3 / R10: hold processor 2 in hard reset
    wr(2'd1, 32'd1);
    check(hreset_n == 4'b1011, "R3 hard reset of 2", hreset_n, 4'b1011);
    req_n = 4'b0000;
    push(3); push(0); push(1); push(3);
    serve(4);
    req_n = 4'hF;

    // R4: soft reset of processor 3
    wr(2'd2, 32'd2);
    check(sreset_n == 4'b0111, "R4 soft reset of 3", sreset_n, 4'b0111);
    check(hreset_n == 4'b1011, "R4 hard resets untouched", hreset_n, 4'b1011);
    wr(2'd1, 32'd0);
    check(hreset_n == 4'hF, "R3 hard reset cleared", hreset_n, 4'hF);

    // R6 / R7: error while processor 2 owns the bus
    req_n = 4'b1011;
    push(2);
    wait_grant();
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check(mchk_n == 4'b1010, "R6 even pair", mchk_n, 4'b1010);
    @(negedge clk);
    check(mchk_n == 4'hF, "R6 one-cycle pulse", mchk_n, 4'hF);
    rd(2'd3, rd_v); check(rd_v[9:8] == 2'b00, "R7 processor 2 not recorded", rd_v[9:8], 0);
    req_n = 4'hF;
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;

    // error while processor 1 owns the bus
    req_n = 4'b1101;
    push(1);
    wait_grant();
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check(mchk_n == 4'b0101, "R6 odd pair", mchk_n, 4'b0101);
    rd(2'd3, rd_v); check(rd_v[9:8] == 2'b10, "R7 processor 1 flag", rd_v[9:8], 2);
    req_n = 4'hF;
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    wr(2'd3, 32'h200);
    rd(2'd3, rd_v); check(rd_v[9:8] == 2'b00, "R7 write-one clear", rd_v[9:8], 0);

    // R8: grant held without completion, idle cycle on release
    req_n = 4'b1110;
    push(0); push(0);
    wait_grant();
    repeat (5) @(negedge clk);
    check(gnt_n == 4'b1110, "R8 grant held", gnt_n, 4'b1110);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    check(gnt_n == 4'hF, "R8 idle after release", gnt_n, 4'hF);
    @(negedge clk);
    check(gnt_n == 4'b1110, "R8 re-grant after idle", gnt_n, 4'b1110);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    req_n = 4'hF;

    // R2 back to two-master mode
    wr(2'd0, 32'd0);
    rd(2'd0, rd_v); check(rd_v == 32'd0, "R2 mode cleared", rd_v, 0);
    req_n = 4'b0000;
    push(1); push(0);
    serve(2);
    req_n = 4'hF;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected grants seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule